// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character into an asynchronous-style serial frame and shifts it out on a single data line. It also drives a serial clock, so a partner device can sample the line in synchronous mode. The frame layout is chosen at run time. There are five data lengths (5 to 9 bits), three parity options (none, even, odd) and one or two stop bits, which gives 30 formats. Every frame opens with a low start bit and closes with high stop bits.

The serial clock comes from a programmable divider. The system clock is divided by 2×(N+1), so each half period of the serial clock lasts N+1 system cycles and each bit lasts 2×(N+1) cycles. A polarity input sets the idle level of the serial clock. The data line always changes on the edge that leaves the idle level: the rising edge for polarity 0 and the falling edge for polarity 1. The partner samples on the opposite edge.

A character is offered with a valid/ready handshake. The format, polarity and divider are latched when the character is accepted. During the last cycle of a frame, ready is raised again, so a waiting character starts with no idle gap.

Top module: `sframe_tx`

## Requirements
- R1: While reset is held or no frame is active:
  - `txd` is 1.
  - `busy` is 0.
  - `tx_ready` is 1.
  - `sclk` equals the live `sclk_pol` input.
- R2: In the system-clock edge that accepts a character (`tx_valid` and `tx_ready` both high), `txd` goes to 0 as the start bit. The data bits follow least significant first. The number of data bits is set by `fmt_len`: codes 0,1,2,3 give 5,6,7,8 bits, and codes 4 to 7 give 9 bits.
- R3: `fmt_parity` selects the parity bit:
  - 2'b10 adds an even-parity bit (XOR of the data bits).
  - 2'b11 adds an odd-parity bit (the inverse of that XOR).
  - 2'b00 and 2'b01 add no bit.
  
  When present, the parity bit sits directly after the last data bit.
- R4: After the data bits and any parity bit come stop bits with `txd`=1: one stop bit when `fmt_stop2`=0, two when it is 1. Once the last stop bit ends with no character waiting, `busy` falls and `txd` stays 1.
- R5: Each bit lasts exactly 2×(`clk_div`+1) system cycles. While a frame is active, `sclk` holds each level for `clk_div`+1 cycles.
- R6: `txd` changes only in the system-clock cycle that produces the serial-clock edge leaving the idle level. That edge is rising for polarity 0 and falling for polarity 1.
- R7: `tx_ready` is 0 throughout a frame, except in its final system cycle.
- R8: If `tx_valid` is high in that final cycle, the next start bit follows the last stop bit with no idle cycle. The new character uses its own format, polarity and divider.
- R9: Format, polarity and divider inputs are captured at acceptance. Changing them during a frame does not alter that frame.
- R10: Data bits above the configured length do not affect the transmitted data or the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_data | input | 9 | Character to send; only the low configured bits are used |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can take a character this cycle |
| fmt_len | input | 3 | Data length code (0..3 give 5..8 bits, 4..7 give 9 bits) |
| fmt_parity | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| fmt_stop2 | input | 1 | 1 selects two stop bits |
| sclk_pol | input | 1 | Serial clock polarity (idle level) |
| clk_div | input | DIV_W | Divider value N; half period is N+1 cycles |
| busy | output | 1 | A frame is being sent |
| sclk | output | 1 | Serial clock output |
| txd | output | 1 | Serial data output |

## Verification
The accepting edge is counted as cycle 0. Results are then due as follows:
- Bit k appears on `txd` k×2(N+1) cycles after cycle 0.
- `sclk` is away from its idle level for the first N+1 cycles of each bit.
- `tx_ready` rises only in cycle F×2(N+1)−1, where F is the frame length in bits.
- The line is idle one cycle later.

The bench drives inputs on the falling clock edge and samples on the falling edge after each rising edge. It walks a cycle counter from acceptance and compares `txd`, `sclk`, `busy` and `tx_ready` against that arithmetic in every cycle. It does this for all 30 formats under both polarities, and again for a chain of back-to-back frames, so a one-cycle slip in any output is caught.

// File: rtl/sframe_pkg.sv
package sframe_pkg;

  localparam int unsigned MAX_DATA = 9;
  localparam int unsigned MIN_DATA = 5;
  // start + data + parity + two stop
  localparam int unsigned FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int unsigned IDX_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_OFF   = 2'b00,
    PAR_OFF_B = 2'b01,
    PAR_EVEN  = 2'b10,
    PAR_ODD   = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [2:0] len_code;
    logic [1:0] par;
    logic       stop2;
  } fmt_t;

endpackage

// File: rtl/sframe_builder.sv
module sframe_builder
  import sframe_pkg::*;
(
  input  fmt_t                 fmt,
  input  logic [MAX_DATA-1:0]  data,
  output logic [FRAME_W-1:0]   frame,
  output logic [IDX_W-1:0]     last_idx
);

  int   nbits;
  int   total;
  logic par_bit;
  logic has_par;

  always_comb begin
    nbits   = (fmt.len_code >= 3'd4) ? int'(MAX_DATA) : int'(MIN_DATA) + int'(fmt.len_code);
    has_par = fmt.par[1];

    // R10: only the active data bits feed parity
    par_bit = 1'b0;
    for (int i = 0; i < int'(MAX_DATA); i++) begin
      if (i < nbits) par_bit = par_bit ^ data[i];
    end
    if (fmt.par == PAR_ODD) par_bit = ~par_bit;

    // line defaults high so stop bits and unused slots are marks
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < int'(MAX_DATA); i++) begin
      if (i < nbits) frame[1+i] = data[i];
    end
    for (int j = 0; j < int'(FRAME_W); j++) begin
      if (has_par && (j == nbits + 1)) frame[j] = par_bit;
    end

    total    = 1 + nbits + (has_par ? 1 : 0) + 1 + (fmt.stop2 ? 1 : 0);
    last_idx = IDX_W'(total - 1);
  end

endmodule

// File: rtl/sframe_baud.sv
module sframe_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: half-period counter never passes the captured divider
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));

  // R5: an idle counter rests at zero
  assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/sframe_tx.sv
module sframe_tx
  import sframe_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_DATA-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [2:0]          fmt_len,
  input  logic [1:0]          fmt_parity,
  input  logic                fmt_stop2,
  input  logic                sclk_pol,
  input  logic [DIV_W-1:0]    clk_div,
  output logic                busy,
  output logic                sclk,
  output logic                txd
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  fmt_t               fmt_in;
  logic [FRAME_W-1:0] frame_w;
  logic [IDX_W-1:0]   last_w;
  logic               tick;

  assign fmt_in = '{len_code: fmt_len, par: fmt_parity, stop2: fmt_stop2};

  sframe_builder u_build (
    .fmt      (fmt_in),
    .data     (tx_data),
    .frame    (frame_w),
    .last_idx (last_w)
  );

  logic               busy_q,  busy_d;
  logic               phase_q, phase_d;   // 1 = serial clock away from idle
  logic [FRAME_W-1:0] sh_q,    sh_d;
  logic [IDX_W-1:0]   rem_q,   rem_d;
  logic               pol_q,   pol_d;
  logic [DIV_W-1:0]   div_q,   div_d;

  sframe_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (busy_q),
    .div   (div_q),
    .tick  (tick)
  );

  logic lead_due, frame_end, accept;

  always_comb begin
    lead_due  = tick && !phase_q;
    frame_end = lead_due && (rem_q == '0);
    tx_ready  = !busy_q || frame_end;
    accept    = tx_valid && tx_ready;

    busy_d  = busy_q;
    phase_d = phase_q;
    sh_d    = sh_q;
    rem_d   = rem_q;
    pol_d   = pol_q;
    div_d   = div_q;

    if (accept) begin
      busy_d  = 1'b1;
      phase_d = 1'b1;
      sh_d    = frame_w;
      rem_d   = last_w;
      pol_d   = sclk_pol;
      div_d   = clk_div;
    end else if (frame_end) begin
      busy_d  = 1'b0;
      phase_d = 1'b0;
      sh_d    = '1;
    end else if (tick) begin
      phase_d = ~phase_q;
      if (lead_due) begin
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      sh_q    <= '1;
      rem_q   <= '0;
      pol_q   <= 1'b0;
      div_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      sh_q    <= sh_d;
      rem_q   <= rem_d;
      pol_q   <= pol_d;
      div_q   <= div_d;
    end
  end

  assign busy = busy_q;
  assign txd  = sh_q[0];
  assign sclk = busy_q ? (phase_q ^ pol_q) : sclk_pol;

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy_q |-> txd);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    accept |=> (!txd && busy_q));

  assert_end_high_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy_q) |-> (txd && tx_ready));

  assert_change_edge_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && $past(busy_q) && !$stable(txd)) |-> (sclk != pol_q));

  assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && !tick) |-> !tx_ready);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && !accept) |=> ($stable(pol_q) && $stable(div_q)));

endmodule

// File: tb/sim_sframe_tx.sv
module sim_sframe_tx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic [2:0] fmt_len;
  logic [1:0] fmt_parity;
  logic       fmt_stop2;
  logic       sclk_pol;
  logic [7:0] clk_div;
  logic       busy, sclk, txd;

  always #10 clk = ~clk;   // 50 MHz

  sframe_tx #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .fmt_len(fmt_len), .fmt_parity(fmt_parity),
    .fmt_stop2(fmt_stop2), .sclk_pol(sclk_pol), .clk_div(clk_div),
    .busy(busy), .sclk(sclk), .txd(txd)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2:0] f_len  [8];
  logic [1:0] f_par  [8];
  logic       f_stop [8];
  logic       f_pol  [8];
  logic [7:0] f_div  [8];
  logic [8:0] f_data [8];
  logic       eb [16];
  int         ef;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input int i);
    int   nb;
    logic p;
    nb = (f_len[i] >= 3'd4) ? 9 : 5 + int'(f_len[i]);
    p  = 1'b0;
    for (int j = 0; j < nb; j++) p = p ^ f_data[i][j];
    eb[0] = 1'b0;
    for (int j = 0; j < nb; j++) eb[1+j] = f_data[i][j];
    ef = 1 + nb;
    if (f_par[i][1]) begin
      eb[ef] = f_par[i][0] ? ~p : p;
      ef = ef + 1;
    end
    eb[ef] = 1'b1; ef = ef + 1;
    if (f_stop[i]) begin eb[ef] = 1'b1; ef = ef + 1; end
  endtask

  task automatic apply(input int i, input logic v);
    tx_data    = f_data[i];
    fmt_len    = f_len[i];
    fmt_parity = f_par[i];
    fmt_stop2  = f_stop[i];
    sclk_pol   = f_pol[i];
    clk_div    = f_div[i];
    tx_valid   = v;
  endtask

  // R9: inputs wander while the frame is on the line
  task automatic scramble();
    tx_valid   = 1'b0;
    tx_data    = 9'($urandom);
    fmt_len    = 3'($urandom);
    fmt_parity = 2'($urandom);
    fmt_stop2  = 1'($urandom);
    sclk_pol   = 1'($urandom);
    clk_div    = 8'($urandom);
  endtask

  task automatic play(input int n);
    int   hp, len, k, bt, bs, br, at, et, as_, es, ar, er;
    logic exp_s, exp_r;
    @(negedge clk);
    apply(0, 1'b1);
    for (int i = 0; i < n; i++) begin
      build(i);
      hp  = int'(f_div[i]) + 1;
      len = ef * 2 * hp;
      bt = -1; bs = -1; br = -1;
      at = 0; et = 0; as_ = 0; es = 0; ar = 0; er = 0;
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if (c == 0) scramble();
        k     = c / (2 * hp);
        exp_s = ((c % (2 * hp)) < hp) ? ~f_pol[i] : f_pol[i];
        exp_r = (c == len - 1);
        if (bt < 0 && txd !== eb[k]) begin bt = c; at = int'(txd); et = int'(eb[k]); end
        if (bs < 0 && sclk !== exp_s) begin bs = c; as_ = int'(sclk); es = int'(exp_s); end
        if (br < 0 && (tx_ready !== exp_r || busy !== 1'b1)) begin
          br = c; ar = int'({busy, tx_ready}); er = int'({1'b1, exp_r});
        end
        if (c == len - 1) begin
          if (i < n - 1) apply(i + 1, 1'b1);
          else           apply(i, 1'b0);
        end
      end
      // R2 R3 R4 R9 R10: bit sequence; R8 when chained
      chk(bt < 0, (n > 1) ? "R8 R2 R3 R4 R9 R10 txd" : "R2 R3 R4 R9 R10 txd", at, et);
      // R5 R6: serial clock levels against bit timing
      chk(bs < 0, "R5 R6 sclk", as_, es);
      // R7: ready low until final cycle, busy throughout
      chk(br < 0, "R7 busy/ready", ar, er);
    end
    @(negedge clk);
    chk(busy == 1'b0 && txd == 1'b1 && tx_ready == 1'b1 && sclk == f_pol[n-1],
        "R4 R1 idle after frame", int'({busy, txd, tx_ready, sclk}),
        int'({1'b0, 1'b1, 1'b1, f_pol[n-1]}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    tx_valid = 1'b0; tx_data = '0; fmt_len = '0; fmt_parity = '0;
    fmt_stop2 = 1'b0; sclk_pol = 1'b1; clk_div = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(txd == 1'b1,      "R1 txd",   int'(txd), 1);
    chk(busy == 1'b0,     "R1 busy",  int'(busy), 0);
    chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
    chk(sclk == 1'b1,     "R1 sclk pol1", int'(sclk), 1);
    sclk_pol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0,     "R1 sclk pol0", int'(sclk), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R1 after release", int'({txd, busy}), 2);

    // all 30 formats, both polarities
    cnt = 0;
    for (int l = 0; l < 5; l++)
      for (int pm = 0; pm < 3; pm++)
        for (int s = 0; s < 2; s++)
          for (int pol = 0; pol < 2; pol++) begin
            f_len[0]  = 3'(l);
            f_par[0]  = (pm == 0) ? 2'b00 : (pm == 1) ? 2'b10 : 2'b11;
            f_stop[0] = 1'(s);
            f_pol[0]  = 1'(pol);
            f_div[0]  = 8'(cnt % 3);
            f_data[0] = 9'($urandom);   // R10: upper bits are garbage
            play(1);
            cnt++;
          end

    // alternate codes: length codes above 4, parity code 01
    f_len[0] = 3'd7; f_par[0] = 2'b01; f_stop[0] = 1'b1; f_pol[0] = 1'b1;
    f_div[0] = 8'd1; f_data[0] = 9'h1A5;
    play(1);
    f_len[0] = 3'd5; f_par[0] = 2'b11; f_stop[0] = 1'b0; f_pol[0] = 1'b0;
    f_div[0] = 8'd4; f_data[0] = 9'h0FF;
    play(1);

    // R8: back-to-back chain with changing format, polarity and divider
    for (int i = 0; i < 5; i++) begin
      f_len[i]  = 3'(i);
      f_par[i]  = (i % 3 == 0) ? 2'b00 : (i % 3 == 1) ? 2'b10 : 2'b11;
      f_stop[i] = 1'(i % 2);
      f_pol[i]  = 1'((i / 2) % 2);
      f_div[i]  = 8'((i * 2) % 5);
      f_data[i] = 9'($urandom);
    end
    play(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule